// File: doc/BRIEF.md
# Multi-Port Ordered Bypass Register

This block is one storage register that several logical ports share. The ports act in a fixed order inside a single clock cycle. Each port has a read output, a write-data input and a one-bit write enable. A port reads the register as it stands after every write from the lower-numbered ports in the same cycle. Port 0 therefore sees the value stored at the last clock edge. Each later port sees that value replaced by the data of the highest-numbered enabled port below it.

At the clock edge the register keeps the last write in port order, which is the data of the highest-numbered enabled port. The scheduling logic around the block decides which ports fire. The block itself only resolves their order.

Data width, port count (1 to 5), reset value and reset style are parameters. The reset style is one of none, synchronous or asynchronous, and the reset input is active low.

Top module: `obr_reg`

## Requirements
- R1: The read on port 0 always equals the value stored at the most recent clock edge, whatever any port writes in the current cycle.
- R2: For port i > 0, the read equals the write data of the highest-numbered enabled port below i. When none of ports 0 to i-1 is enabled, it equals the stored value. Port p's data occupies bits [p*WIDTH +: WIDTH] of `wr_data`, and its read occupies the same bits of `rd_data`.
- R3: At a rising clock edge with reset inactive and at least one enabled port, the register takes the write data of the highest-numbered enabled port.
- R4: At a rising clock edge with reset inactive and no enabled port, the register keeps its value.
- R5: In synchronous style, every rising edge with `rst_n` low loads `RST_VAL`, whatever the enables are.
- R6: In asynchronous style, the register takes `RST_VAL` as soon as `rst_n` falls, with no clock edge needed.
- R7: In asynchronous style, while `rst_n` is low every port's write is ignored. All reads show `RST_VAL` and nothing is captured. Writes take effect again once `rst_n` is high.
- R8: In the no-reset style, `rst_n` has no effect: contents survive it, and writes made while it is low are captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, used as the reset style selects |
| wr_en | input | NPORTS | Write enable, one bit per port, bit p for port p |
| wr_data | input | NPORTS*WIDTH | Write data, port p in bits [p*WIDTH +: WIDTH] |
| rd_data | output | NPORTS*WIDTH | Read value, port p in bits [p*WIDTH +: WIDTH] |

## Verification
The assertions check four things on every cycle:
- port 0 tracks the stored value;
- each later port either forwards the data of the enabled port just below it or passes through the read of that port;
- the edge captures the data of the highest enabled port, found by a separate priority search;
- an idle edge holds the value.

Further assertions check that each reset style holds or loads `RST_VAL` while reset is low. Some behaviours only the bench scenarios can show:
- the asynchronous reset acting in the middle of a cycle, before any edge;
- writes resuming after reset is released;
- the no-reset variant keeping its contents through a reset pulse;
- the full set of eight enable patterns on a three-port instance, compared against an ordered reference model.

// File: rtl/obr_pkg.sv
package obr_pkg;

  typedef enum logic [1:0] {
    OBR_RST_NONE  = 2'd0,
    OBR_RST_SYNC  = 2'd1,
    OBR_RST_ASYNC = 2'd2
  } obr_rst_e;

  localparam int OBR_MAX_PORTS = 5;

  // Index of the highest set enable bit, or -1 when none is set.
  function automatic int obr_last_port(input logic [OBR_MAX_PORTS-1:0] en);
    int r;
    r = -1;
    for (int i = 0; i < OBR_MAX_PORTS; i++) begin
      if (en[i]) r = i;
    end
    return r;
  endfunction

  // True when any enable bit is set.
  function automatic logic obr_any(input logic [OBR_MAX_PORTS-1:0] en);
    return obr_last_port(en) >= 0;
  endfunction

endpackage

// File: rtl/obr_gate.sv
module obr_gate #(
  parameter int NPORTS = 3
) (
  input  logic [NPORTS-1:0] en_in,
  input  logic              block,
  output logic [NPORTS-1:0] en_out,
  output logic              any_out
);
  import obr_pkg::*;

  logic [OBR_MAX_PORTS-1:0] en_pad;

  for (genvar g = 0; g < NPORTS; g++) begin : g_mask
    assign en_out[g] = en_in[g] & ~block;
  end

  always_comb begin
    en_pad = '0;
    en_pad[NPORTS-1:0] = en_out;
  end

  assign any_out = obr_any(en_pad);

endmodule

// File: rtl/obr_chain.sv
module obr_chain #(
  parameter int WIDTH  = 8,
  parameter int NPORTS = 3
) (
  input  logic [WIDTH-1:0]        q,
  input  logic [NPORTS-1:0]       en,
  input  logic [NPORTS*WIDTH-1:0] wdata,
  output logic [NPORTS*WIDTH-1:0] rdata,
  output logic [WIDTH-1:0]        nxt
);
  // stg[k] is the value seen after ports 0..k-1 have acted.
  logic [WIDTH-1:0] stg [NPORTS+1];

  assign stg[0] = q;

  for (genvar g = 0; g < NPORTS; g++) begin : g_stage
    assign rdata[g*WIDTH +: WIDTH] = stg[g];
    assign stg[g+1] = en[g] ? wdata[g*WIDTH +: WIDTH] : stg[g];
  end

  assign nxt = stg[NPORTS];

endmodule

// File: rtl/obr_store.sv
module obr_store
  import obr_pkg::*;
#(
  parameter int             WIDTH     = 8,
  parameter obr_rst_e       RST_STYLE = OBR_RST_SYNC,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (RST_STYLE == OBR_RST_ASYNC) begin : g_async
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
    end

    always @(posedge clk) begin
      if (!rst_n) begin
        AST_ASYNC_HELD: assert (q == RST_VAL); // R6
      end
    end
  end else if (RST_STYLE == OBR_RST_SYNC) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
    end

    AST_SYNC_LOAD: assert property (@(posedge clk)
      !rst_n |=> q == RST_VAL); // R5
  end else begin : g_none
    always_ff @(posedge clk) begin
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/obr_reg.sv
module obr_reg
  import obr_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               NPORTS    = 3,
  parameter obr_rst_e         RST_STYLE = OBR_RST_SYNC,
  parameter logic [WIDTH-1:0] RST_VAL   = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       wr_en,
  input  logic [NPORTS*WIDTH-1:0] wr_data,
  output logic [NPORTS*WIDTH-1:0] rd_data
);

  localparam int PAD = OBR_MAX_PORTS;

  logic              block_wr;
  logic [NPORTS-1:0] eff_en;
  logic              any_wr;
  logic [WIDTH-1:0]  q;
  logic [WIDTH-1:0]  nxt;

  // Named views for the assertions.
  logic [WIDTH-1:0]  wd_arr [NPORTS];
  logic [WIDTH-1:0]  rd_arr [NPORTS];
  logic [PAD-1:0]    en_pad;
  int                last_idx;
  logic [WIDTH-1:0]  last_data;

  if (RST_STYLE == OBR_RST_ASYNC) begin : g_blk_async
    assign block_wr = ~rst_n;
  end else begin : g_blk_open
    assign block_wr = 1'b0;
  end

  obr_gate #(.NPORTS(NPORTS)) u_gate (
    .en_in  (wr_en),
    .block  (block_wr),
    .en_out (eff_en),
    .any_out(any_wr)
  );

  obr_chain #(.WIDTH(WIDTH), .NPORTS(NPORTS)) u_chain (
    .q    (q),
    .en   (eff_en),
    .wdata(wr_data),
    .rdata(rd_data),
    .nxt  (nxt)
  );

  obr_store #(.WIDTH(WIDTH), .RST_STYLE(RST_STYLE), .RST_VAL(RST_VAL)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .load (any_wr),
    .d    (nxt),
    .q    (q)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_view
    assign wd_arr[g] = wr_data[g*WIDTH +: WIDTH];
    assign rd_arr[g] = rd_data[g*WIDTH +: WIDTH];
  end

  always_comb begin
    en_pad = '0;
    en_pad[NPORTS-1:0] = eff_en;
    last_idx  = obr_last_port(en_pad);
    last_data = q;
    for (int i = 0; i < NPORTS; i++) begin
      if (i == last_idx) last_data = wd_arr[i];
    end
  end

  AST_PORT0_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_arr[0] == q); // R1

  for (genvar g = 1; g < NPORTS; g++) begin : g_fwd_chk
    AST_FWD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      eff_en[g-1] |-> rd_arr[g] == wd_arr[g-1]); // R2
    AST_FWD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_en[g-1] |-> rd_arr[g] == rd_arr[g-1]); // R2
  end

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> q == $past(last_data)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> q == $past(q)); // R4

  if (RST_STYLE == OBR_RST_ASYNC) begin : g_mask_chk
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
      always @(posedge clk) begin
        if (!rst_n) begin
          AST_ASYNC_MASK: assert (rd_arr[g] == RST_VAL); // R7
        end
      end
    end
  end

endmodule

// File: tb/tb_obr_reg.sv
module tb_obr_reg;
  import obr_pkg::*;

  localparam int W = 8;
  localparam int N = 3;
  localparam logic [W-1:0] RV = 8'hA5;
  localparam logic [N-1:0] EN_TAB [16] = '{
    3'b111, 3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110,
    3'b000, 3'b110, 3'b101, 3'b100, 3'b011, 3'b010, 3'b001, 3'b111
  };

  logic clk = 1'b0;
  logic rst_n, arst_n, nrst_n;
  logic [N-1:0]   wr_en;
  logic [N*W-1:0] wr_data;
  logic [N*W-1:0] rd_s, rd_a, rd_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] mq_s, mq_a;

  always #4 clk = ~clk;

  obr_reg #(.WIDTH(W), .NPORTS(N), .RST_STYLE(OBR_RST_SYNC), .RST_VAL(RV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_s));
  obr_reg #(.WIDTH(W), .NPORTS(N), .RST_STYLE(OBR_RST_ASYNC), .RST_VAL(RV)) dut_async (
    .clk(clk), .rst_n(arst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a));
  obr_reg #(.WIDTH(W), .NPORTS(N), .RST_STYLE(OBR_RST_NONE), .RST_VAL(RV)) dut_nr (
    .clk(clk), .rst_n(nrst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_n));

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] port(input logic [N*W-1:0] v, input int p);
    return v[p*W +: W];
  endfunction

  task automatic drive(input logic [N-1:0] en, input logic [W-1:0] d0,
                       input logic [W-1:0] d1, input logic [W-1:0] d2);
    @(negedge clk);
    wr_en = en;
    wr_data = {d2, d1, d0};
    #2;
  endtask

  initial begin
    rst_n = 1'b0; arst_n = 1'b1; nrst_n = 1'b0;
    wr_en = '0; wr_data = '0;
    #1 arst_n = 1'b0;

    // Reset state
    drive(3'b000, 0, 0, 0);
    drive(3'b000, 0, 0, 0);
    chk("R5", "sync reset value", port(rd_s, 0), RV);
    chk("R6", "async reset value", port(rd_a, 0), RV);
    // Writes during reset
    drive(3'b111, 8'h10, 8'h20, 8'h30);
    chk("R7", "async port1 masked", port(rd_a, 1), RV);
    chk("R7", "async port2 masked", port(rd_a, 2), RV);
    drive(3'b000, 0, 0, 0);
    chk("R5", "sync reset ignores enables", port(rd_s, 0), RV);
    chk("R7", "async nothing captured", port(rd_a, 0), RV);
    rst_n = 1'b1; arst_n = 1'b1;
    mq_s = RV; mq_a = RV;

    // Table of all enable patterns, twice
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] d [N];
      logic [W-1:0] cur;
      string req;
      for (int p = 0; p < N; p++) d[p] = W'(k * 37 + p * 11 + 3);
      @(negedge clk);
      if (k == 1) nrst_n = 1'b1;
      wr_en = EN_TAB[k];
      wr_data = {d[2], d[1], d[0]};
      #2;
      cur = mq_s;
      for (int p = 0; p < N; p++) begin
        if (p == 0) req = (k > 0 && EN_TAB[k-1] != 0) ? "R3" : ((k > 0) ? "R4" : "R1");
        else req = "R2";
        chk(req, $sformatf("sync vec %0d port %0d", k, p), port(rd_s, p), cur);
        chk(req, $sformatf("async vec %0d port %0d", k, p), port(rd_a, p), cur);
        if (k >= 1) chk(req, $sformatf("noreset vec %0d port %0d", k, p), port(rd_n, p), cur);
        if (EN_TAB[k][p]) cur = d[p];
      end
      mq_s = cur; mq_a = cur;
    end

    // R1: port 0 ignores same-cycle writes; R2 highest enabled below
    drive(3'b111, 8'h11, 8'h22, 8'h33);
    chk("R1", "port0 before writes", port(rd_s, 0), mq_s);
    chk("R2", "port2 sees port1", port(rd_s, 2), 8'h22);
    mq_s = 8'h33; mq_a = 8'h33;
    drive(3'b000, 0, 0, 0);
    chk("R3", "highest port captured", port(rd_s, 0), 8'h33);
    chk("R3", "highest port captured async", port(rd_a, 0), 8'h33);

    // R6: asynchronous reset mid-cycle
    @(negedge clk);
    wr_en = '0;
    #1 arst_n = 1'b0;
    #1;
    chk("R6", "async reset before edge", port(rd_a, 0), RV);
    chk("R4", "sync unaffected", port(rd_s, 0), 8'h33);
    drive(3'b111, 8'h44, 8'h55, 8'h66);
    chk("R7", "async port1 masked", port(rd_a, 1), RV);
    chk("R7", "async port2 masked", port(rd_a, 2), RV);
    @(negedge clk);
    wr_en = '0;
    arst_n = 1'b1;
    #2;
    chk("R7", "async nothing captured", port(rd_a, 0), RV);
    chk("R3", "sync captured port2", port(rd_s, 0), 8'h66);
    drive(3'b010, 8'h00, 8'h3C, 8'h00);
    drive(3'b000, 0, 0, 0);
    chk("R7", "async write resumes", port(rd_a, 0), 8'h3C);
    chk("R3", "sync single write", port(rd_s, 0), 8'h3C);

    // R8: reset has no effect on the no-reset variant
    @(negedge clk);
    nrst_n = 1'b0;
    #2;
    drive(3'b000, 0, 0, 0);
    chk("R8", "contents kept through reset", port(rd_n, 0), 8'h3C);
    drive(3'b001, 8'h77, 0, 0);
    drive(3'b000, 0, 0, 0);
    chk("R8", "write during reset captured", port(rd_n, 0), 8'h77);

    // R5: synchronous reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    drive(3'b101, 8'h81, 8'h82, 8'h83);
    drive(3'b000, 0, 0, 0);
    chk("R5", "sync reset mid-run", port(rd_s, 0), RV);
    @(negedge clk);
    rst_n = 1'b1; nrst_n = 1'b1;
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule